// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block decides which of up to fifteen interrupt request flags a small 8-bit core services next. Each source has its own enable bit and its own priority bit (0 low, 1 high), and one global enable gates every source. The request lines are captured into a sample register on every clock edge, and each clock is one machine cycle. The selection logic then works on that sample during the following cycle. When a request is eligible, it makes a vector request only in the cycle in which the core marks the final cycle of an instruction, and only when no blocking condition holds.

The block keeps one "level in service" flag for the low level and one for the high level. A grant sets the flag of the granted level. A return strobe from the core clears the highest flag that is set. A high request can interrupt a low-level handler, and nothing can interrupt a high-level handler. With each grant the block also pulses a clear line for the granted flag. It does this for the timer sources always, and for the external sources only when that input is set up as edge-triggered. Every other flag is left for software to clear. A small byte-wide port holds the enable and priority bits. Any access through this port, like a return, holds off vectoring until one more instruction has completed.

Top module: `irq_arbiter`

## Requirements
- R1: Four byte registers, all zero after reset and read back combinationally on rdata_o. Address 0 holds the enables of sources 0..7 (bit n = source n). Address 1 bits 0..6 hold the enables of sources 8..14, and bit 7 is the global enable. Address 2 bits 0..7 hold the priorities of sources 0..7. Address 3 bits 0..6 hold the priorities of sources 8..14, and bit 7 reads 0.
- R2: A source is granted only if its individual enable, the global enable and its sampled request are all 1.
- R3: Selection uses the req_i value captured at the previous rising clock edge. A request that is dropped before being granted leaves no trace.
- R4: A high-priority candidate beats any low one. Within a level, the lowest source index wins.
- R5: vec_o is 1 only in a cycle where instr_end_i is 1.
- R6: While the low-level flag is set, only high requests are granted. While the high-level flag is set, nothing is granted.
- R7: No grant occurs in a cycle with reti_i, we_i or re_i asserted. No grant occurs at any later cycle until instr_end_i has been seen in or after that strobe's cycle.
- R8: A grant sets lvl_act_o bit 1 (high) or bit 0 (low) at the next edge. reti_i clears bit 1 if it is set, otherwise bit 0.
- R9: With a grant, clr_o is one-hot at the granted index for sources 1 and 3 (timers). For sources 0 and 2 (external) it is one-hot only if ext_edge_i of that index is 1. In all other cases clr_o is zero.
- R10: vec_addr_o equals 3 + 8 × vec_idx_o, and vec_hi_o gives the level of the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 15 | Raw interrupt request flags |
| ext_edge_i | input | 15 | Per-source edge-trigger configuration (used for external sources) |
| instr_end_i | input | 1 | Final cycle of the executing instruction |
| reti_i | input | 1 | Return-from-interrupt strobe |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| vec_o | output | 1 | Vector request to the core |
| vec_idx_o | output | 4 | Granted source index |
| vec_hi_o | output | 1 | Granted level (1 high) |
| vec_addr_o | output | 16 | Service routine address |
| clr_o | output | 15 | Hardware clear pulse for the granted flag |
| lvl_act_o | output | 2 | Level-in-service flags {high, low} |

## Verification
The hardest state to reach is nesting: a low handler must be in service, a high request must arrive and take over, and then a return must clear only the high flag while the low flag stays set. This only happens through a timed series of grants and returns. Directed sequences build that state step by step and check lvl_act_o after every step. Long random runs mix returns, register accesses and instruction boundaries so that pending holds overlap with arriving and vanishing requests. A bench model predicts every cycle of this.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 15,
  parameter int ADDRW = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter logic [NSRC-1:0] HWCLR_MASK = 15'b000_0000_0000_1010,
  parameter logic [NSRC-1:0] EXT_MASK   = 15'b000_0000_0000_0101,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_i,
  input  logic [NSRC-1:0]  ext_edge_i,
  input  logic             instr_end_i,
  input  logic             reti_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             vec_o,
  output logic [IDXW-1:0]  vec_idx_o,
  output logic             vec_hi_o,
  output logic [ADDRW-1:0] vec_addr_o,
  output logic [NSRC-1:0]  clr_o,
  output logic [1:0]       lvl_act_o
);
  logic [NSRC-1:0] en_q, pr_q, req_q, elig;
  logic            ge_q, blk_q, strobe, sel_hi, sel_lo, hi_any, lo_any;
  logic [IDXW-1:0] hi_idx, lo_idx;
  logic [1:0]      act_q;

  assign strobe = reti_i | we_i | re_i;
  assign elig   = req_q & en_q & {NSRC{ge_q}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= '0;
      pr_q <= '0;
      ge_q <= 1'b0;
    end else if (we_i) begin
      for (int i = 0; i < NSRC; i++) begin
        if (i < 8 && addr_i == 2'd0) en_q[i] <= wdata_i[i % 8];
        if (i >= 8 && addr_i == 2'd1) en_q[i] <= wdata_i[i % 8];
        if (i < 8 && addr_i == 2'd2) pr_q[i] <= wdata_i[i % 8];
        if (i >= 8 && addr_i == 2'd3) pr_q[i] <= wdata_i[i % 8];
      end
      if (addr_i == 2'd1) ge_q <= wdata_i[7];
    end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (i < 8 && addr_i == 2'd0) rdata_o[i % 8] = en_q[i];
      if (i >= 8 && addr_i == 2'd1) rdata_o[i % 8] = en_q[i];
      if (i < 8 && addr_i == 2'd2) rdata_o[i % 8] = pr_q[i];
      if (i >= 8 && addr_i == 2'd3) rdata_o[i % 8] = pr_q[i];
    end
    if (addr_i == 2'd1) rdata_o[7] = ge_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;

  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && pr_q[i]) begin
        hi_any = 1'b1;
        hi_idx = IDXW'(i);
      end
      if (elig[i] && !pr_q[i]) begin
        lo_any = 1'b1;
        lo_idx = IDXW'(i);
      end
    end
  end

  assign sel_hi     = hi_any && !act_q[1];
  assign sel_lo     = !sel_hi && lo_any && (act_q == 2'b00);
  assign vec_o      = instr_end_i && !blk_q && !strobe && (sel_hi || sel_lo);
  assign vec_hi_o   = sel_hi;
  assign vec_idx_o  = sel_hi ? hi_idx : lo_idx;
  assign vec_addr_o = ADDRW'(VEC_BASE) + ADDRW'(vec_idx_o) * ADDRW'(VEC_STEP);
  assign clr_o      = vec_o ? ((NSRC'(1) << vec_idx_o) & (HWCLR_MASK | (EXT_MASK & ext_edge_i)))
                            : '0;
  assign lvl_act_o  = act_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= (blk_q | strobe) & !instr_end_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_q <= 2'b00;
    else if (vec_o) begin
      if (sel_hi) act_q[1] <= 1'b1;
      else        act_q[0] <= 1'b1;
    end else if (reti_i) begin
      if (act_q[1]) act_q[1] <= 1'b0;
      else          act_q[0] <= 1'b0;
    end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NSRC = 15,
  localparam int IDXW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_end_i,
  input logic            reti_i,
  input logic            we_i,
  input logic            re_i,
  input logic            vec_o,
  input logic            vec_hi_o,
  input logic [IDXW-1:0] vec_idx_o,
  input logic [NSRC-1:0] clr_o,
  input logic [1:0]      lvl_act_o,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] req_q,
  input logic            ge_q
);
  a_r2_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o |-> (ge_q && en_q[vec_idx_o] && req_q[vec_idx_o]));
  a_r5_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o |-> instr_end_i);
  a_r6_high_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_act_o[1] |-> !vec_o);
  a_r6_low_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_act_o[0] && vec_o) |-> vec_hi_o);
  a_r7_strobe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i || we_i || re_i) |-> !vec_o);
  a_r7_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti_i || we_i || re_i) && !$past(instr_end_i)) |-> !vec_o);
  a_r8_grant_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o && vec_hi_o) |=> lvl_act_o[1]);
  a_r8_low_grant_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o && !vec_hi_o) |=> lvl_act_o[0]);
  a_r9_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));
  a_r9_clear_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_o) |-> vec_o);
endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_end_i(instr_end_i), .reti_i(reti_i),
  .we_i(we_i), .re_i(re_i), .vec_o(vec_o), .vec_hi_o(vec_hi_o),
  .vec_idx_o(vec_idx_o), .clr_o(clr_o), .lvl_act_o(lvl_act_o),
  .en_q(en_q), .req_q(req_q), .ge_q(ge_q)
);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic clk = 0, rst_n = 0;
  logic [14:0] req_i = 0, ext_edge_i = 0, clr_o;
  logic instr_end_i = 0, reti_i = 0, we_i = 0, re_i = 0, vec_o, vec_hi_o;
  logic [1:0] addr_i = 0, lvl_act_o;
  logic [7:0] wdata_i = 0, rdata_o;
  logic [3:0] vec_idx_o;
  logic [15:0] vec_addr_o;
  int nchk = 0, nbad = 0;

  logic [14:0] m_en = 0, m_pr = 0, m_rq = 0;
  logic m_ge = 0, m_blk = 0;
  logic [1:0] m_act = 0;
  localparam logic [14:0] HW = 15'b1010, EXT = 15'b0101;

  always #10 clk = ~clk;

  irq_arbiter u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] pick(input logic [14:0] rq, en, pr, input logic ge,
                                      input logic [1:0] act);
    logic [14:0] e = rq & en & {15{ge}};
    for (int i = 0; i < 15; i++)
      if (e[i] && pr[i] && !act[1]) return {1'b1, 1'b1, 4'(i)};
    for (int i = 0; i < 15; i++)
      if (e[i] && !pr[i] && act == 2'b00) return {1'b1, 1'b0, 4'(i)};
    return 6'd0;
  endfunction

  function automatic logic [7:0] mread(input logic [1:0] a);
    case (a)
      2'd0: return m_en[7:0];
      2'd1: return {m_ge, m_en[14:8]};
      2'd2: return m_pr[7:0];
      default: return {1'b0, m_pr[14:8]};
    endcase
  endfunction

  task automatic step(input logic [14:0] rq, input logic ie, rt, we, re,
                      input logic [1:0] a, input logic [7:0] wd,
                      input logic [14:0] edg, input string tag);
    logic [5:0] w;
    logic f;
    @(negedge clk);
    req_i = rq; instr_end_i = ie; reti_i = rt; we_i = we; re_i = re;
    addr_i = a; wdata_i = wd; ext_edge_i = edg;
    #1;
    w = pick(m_rq, m_en, m_pr, m_ge, m_act);
    f = ie && !m_blk && !(rt || we || re) && w[5];
    chk(vec_o == f, {tag, " vec"}, vec_o, f);
    chk(lvl_act_o == m_act, {tag, " lvl"}, lvl_act_o, m_act);
    if (f && vec_o) begin
      chk(vec_idx_o == w[3:0], {tag, " idx"}, vec_idx_o, w[3:0]);
      chk(vec_hi_o == w[4], {tag, " hi"}, vec_hi_o, w[4]);
      chk(vec_addr_o == 16'(3 + 8 * w[3:0]), {tag, " R10 addr"}, vec_addr_o, 3 + 8 * w[3:0]);
      chk(clr_o == ((15'd1 << w[3:0]) & (HW | (EXT & edg))), {tag, " R9 clr"},
          clr_o, (15'd1 << w[3:0]) & (HW | (EXT & edg)));
    end else chk(clr_o == 0, {tag, " R9 clr idle"}, clr_o, 0);
    if (re) chk(rdata_o == mread(a), {tag, " R1 read"}, rdata_o, mread(a));
    @(posedge clk);
    m_rq = rq;
    if (f) begin
      if (w[4]) m_act[1] = 1; else m_act[0] = 1;
    end else if (rt) begin
      if (m_act[1]) m_act[1] = 0; else m_act[0] = 0;
    end
    m_blk = (m_blk | rt | we | re) & !ie;
    if (we) case (a)
      2'd0: m_en[7:0] = wd;
      2'd1: begin m_en[14:8] = wd[6:0]; m_ge = wd[7]; end
      2'd2: m_pr[7:0] = wd;
      default: m_pr[14:8] = wd[6:0];
    endcase
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(0, 1, 0, 1, 0, a, d, 0, tag);
  endtask
  task automatic go(input logic [14:0] rq, input logic ie, input logic [14:0] edg,
                    input string tag);
    step(rq, ie, 0, 0, 0, 0, 0, edg, tag);
  endtask
  task automatic ret(input string tag);
    step(0, 1, 1, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #35 rst_n = 1;
    // R1 reset values and read back
    for (int a = 0; a < 4; a++) step(0, 0, 0, 0, 1, 2'(a), 0, 0, "R1 reset");
    go(0, 1, 0, "R1 idle");
    wr(0, 8'hFF, "R1"); wr(1, 8'hFF, "R1");
    for (int a = 0; a < 4; a++) step(0, 0, 0, 0, 1, 2'(a), 0, 0, "R1 readback");
    go(0, 1, 0, "R7 settle");
    // R3 request sampled then dropped still wins
    go(15'h20, 0, 0, "R3 sample");
    go(0, 1, 0, "R3 from sample");
    ret("R8 reti low"); go(0, 1, 0, "R7 post reti");
    // R3 blocked request that vanishes is lost
    go(15'h40, 0, 0, "R5 no boundary");
    go(0, 0, 0, "R3 gone");
    go(0, 1, 0, "R3 lost");
    // R4 same level lowest index
    go(15'h208, 0, 0, "R4 setup");
    go(15'h208, 1, 0, "R4 lowest idx");
    ret("R8"); go(0, 1, 0, "R7");
    // R4 high beats low
    wr(3, 8'h02, "R4 prio"); go(0, 1, 0, "R7");
    go(15'h208, 0, 0, "R4 setup");
    go(15'h208, 1, 0, "R4 high wins");
    go(15'h208, 1, 0, "R6 high blocks all");
    ret("R8 clear high"); go(0, 1, 0, "R7");
    // R6 nesting: low then high preempts, then reti clears high only
    go(15'h8, 0, 0, "R6 setup");
    go(15'h8, 1, 0, "R6 low grant");
    go(15'h8, 1, 0, "R6 low blocked");
    go(15'h200, 0, 0, "R6 high arrives");
    go(15'h200, 1, 0, "R6 high preempts");
    go(15'h208, 1, 0, "R6 both active");
    ret("R8 clears high only");
    go(0, 1, 0, "R8 low still set");
    ret("R8 clears low"); go(0, 1, 0, "R7");
    // R7 access in mid instruction blocks next boundary
    go(15'h10, 0, 0, "R7 setup");
    step(15'h10, 0, 0, 0, 1, 2'd0, 0, 0, "R7 read strobe");
    go(15'h10, 1, 0, "R7 blocked boundary");
    go(15'h10, 1, 0, "R7 released");
    ret("R8"); go(0, 1, 0, "R7");
    // R2 global disable
    wr(1, 8'h7F, "R2 ge off"); go(0, 1, 0, "R7");
    go(15'h10, 0, 0, "R2 setup"); go(15'h10, 1, 0, "R2 no grant");
    wr(1, 8'hFF, "R2 ge on"); wr(0, 8'hEF, "R2 src4 off"); go(15'h10, 1, 0, "R7");
    go(15'h10, 1, 0, "R2 src4 disabled");
    wr(0, 8'hFF, "R2"); go(0, 1, 0, "R7");
    // R9 clears
    go(15'h1, 0, 15'h1, "R9"); go(15'h1, 1, 15'h1, "R9 ext edge");
    ret("R8"); go(0, 1, 0, "R7");
    go(15'h4, 0, 0, "R9"); go(15'h4, 1, 0, "R9 ext level");
    ret("R8"); go(0, 1, 0, "R7");
    go(15'h2, 0, 0, "R9"); go(15'h2, 1, 0, "R9 timer");
    ret("R8"); go(0, 1, 0, "R7");
    go(15'h800, 0, 0, "R10"); go(15'h800, 1, 15'h7FFF, "R10 high idx");
    ret("R8"); go(0, 1, 0, "R7");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [14:0] rq = 15'($urandom) & 15'($urandom);
      logic [14:0] edg = 15'($urandom);
      logic ie = ($urandom_range(0, 2) != 0);
      if (r < 6) step(rq, ie, 0, 1, 0, 2'($urandom), 8'($urandom) | 8'h80 * (r % 2),
                      edg, "R4 rand write");
      else if (r < 10) step(rq, ie, 0, 0, 1, 2'($urandom), 0, edg, "R4 rand read");
      else if (r < 22) step(rq, ie, 1, 0, 0, 0, 0, edg, "R8 rand reti");
      else step(rq, ie, 0, 0, 0, 0, 0, edg, "R4 rand");
    end
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule